// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This unit gathers interrupt sources from a serial bus controller into one raw status word. Two kinds of sources feed it. Level sources are the live occupancy flags of the transmit and receive FIFOs, and the raw word simply tracks them. Event sources are single-cycle pulses from the transaction engine and from the transmit overrun detector. These are latched and stay set until software clears them.

A mask word selects which raw bits may raise the interrupt line. The masked word is the raw word gated by that mask. A write-one-to-clear port removes latched event bits. Only a fixed subset of the 32 bit positions is implemented. Every other position is a hole: it reads as zero in every view and cannot be set, masked or cleared.

The bus adapter in front of the unit performs the register reads and writes through the plain ports listed below.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw word, the mask word and the masked word all read zero, and `irq_o` is low.
- R2: The event bits are 3, 16, 17, 18, 19, 20, 24, 25 and 28. A one-cycle pulse on such a bit of `evt_pulse_i` sets that raw bit at the next clock edge, and the bit stays set after the pulse ends.
- R3: When a clear write has bit n high, raw event bit n goes to zero at the next edge. Clear-word bits that are low leave their raw bits unchanged.
- R4: The level bits are 0, 1, 2, 4, 5 and 6. Each raw level bit equals that bit of `lvl_flag_i` as sampled at the most recent edge. Event pulses and clear writes do not change level bits.
- R5: Only positions in the pattern 0x131F007F are implemented, so bits 29 to 31 are always reserved. Reserved positions read zero in the raw, mask and masked words whatever the inputs.
- R6: `masked_stat_o` equals the bitwise AND of `raw_stat_o` and `mask_o`.
- R7: `irq_o` equals the OR of all bits of the masked word one clock cycle earlier.
- R8: If an event pulse and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R9: A mask write stores `mask_wdata_i` ANDed with the implemented pattern. The new value is visible from the next edge and is held until the next mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 32 | One-cycle event pulses, one per bit position |
| lvl_flag_i | input | 32 | Live FIFO level flags, one per bit position |
| mask_we_i | input | 1 | Mask word write strobe |
| mask_wdata_i | input | 32 | Mask word write data |
| clr_we_i | input | 1 | Clear word write strobe |
| clr_wdata_i | input | 32 | Clear word data; ones clear latched event bits |
| raw_stat_o | output | 32 | Raw status word |
| mask_o | output | 32 | Current mask word |
| masked_stat_o | output | 32 | Raw status gated by the mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with its default 32-bit word, the 0x131F007F implemented pattern and the 0x77 level pattern. This small configuration allows every one of the 32 positions to be swept in turn.

For each position the bench runs the same sequence:
- latch a pulse,
- hold it,
- mask it,
- watch the interrupt one cycle later,
- clear it with a complementary word and then with a matching word,
- drive the level flag together with a clear,
- collide a set with a clear.

Each expected value is derived from the position's class (level, event or reserved), so level, sticky and hole behaviour are all checked at every bit. Whole-word patterns then check the combined mask gating.

// File: rtl/isu_pkg.sv
package isu_pkg;
    localparam int unsigned ISU_REG_W = 32;
    // Positions that physically exist in the status word.
    localparam logic [ISU_REG_W-1:0] ISU_IMPL_MAP  = 32'h131F_007F;
    // Implemented positions that follow live FIFO flags; the rest latch.
    localparam logic [ISU_REG_W-1:0] ISU_LEVEL_MAP = 32'h0000_0077;
endpackage

// File: rtl/isu_raw_bank.sv
module isu_raw_bank #(
    parameter int unsigned  REG_W     = isu_pkg::ISU_REG_W,
    parameter logic [REG_W-1:0] IMPL_MAP  = isu_pkg::ISU_IMPL_MAP,
    parameter logic [REG_W-1:0] LEVEL_MAP = isu_pkg::ISU_LEVEL_MAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic [REG_W-1:0] lvl_i,
    input  logic             clr_we_i,
    input  logic [REG_W-1:0] clr_data_i,
    output logic [REG_W-1:0] raw_o
);
    localparam logic [REG_W-1:0] LVL_BITS    = LEVEL_MAP & IMPL_MAP;
    localparam logic [REG_W-1:0] STICKY_BITS = IMPL_MAP & ~LEVEL_MAP;

    typedef struct packed {
        logic [REG_W-1:0] raw;
    } bank_t;

    bank_t st_d, st_q;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] nxt_bits;

    assign clr_vec = clr_we_i ? clr_data_i : '0;

    // Each position picks its own update rule from the two maps.
    for (genvar i = 0; i < int'(REG_W); i++) begin : g_bit
        if (LVL_BITS[i]) begin : g_level
            assign nxt_bits[i] = lvl_i[i];
        end else if (STICKY_BITS[i]) begin : g_sticky
            // A set in the same cycle overrides the clear.
            assign nxt_bits[i] = evt_i[i] | (st_q.raw[i] & ~clr_vec[i]);
        end else begin : g_hole
            assign nxt_bits[i] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.raw = nxt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

    // Hole positions of the inputs feed no logic.
    logic unused_holes;
    assign unused_holes = ^{evt_i & ~STICKY_BITS, lvl_i & ~LVL_BITS, clr_vec & ~STICKY_BITS};
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
    parameter int unsigned  REG_W    = isu_pkg::ISU_REG_W,
    parameter logic [REG_W-1:0] IMPL_MAP = isu_pkg::ISU_IMPL_MAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] mask_o
);
    typedef struct packed {
        logic [REG_W-1:0] mask;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) st_d.mask = wdata_i & IMPL_MAP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/isu_irq_reduce.sv
module isu_irq_reduce #(
    parameter int unsigned REG_W = isu_pkg::ISU_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] raw_i,
    input  logic [REG_W-1:0] mask_i,
    output logic [REG_W-1:0] masked_o,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } red_t;

    red_t st_d, st_q;

    assign masked_o = raw_i & mask_i;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int unsigned  REG_W     = isu_pkg::ISU_REG_W,
    parameter logic [REG_W-1:0] IMPL_MAP  = isu_pkg::ISU_IMPL_MAP,
    parameter logic [REG_W-1:0] LEVEL_MAP = isu_pkg::ISU_LEVEL_MAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_pulse_i,
    input  logic [REG_W-1:0] lvl_flag_i,
    input  logic             mask_we_i,
    input  logic [REG_W-1:0] mask_wdata_i,
    input  logic             clr_we_i,
    input  logic [REG_W-1:0] clr_wdata_i,
    output logic [REG_W-1:0] raw_stat_o,
    output logic [REG_W-1:0] mask_o,
    output logic [REG_W-1:0] masked_stat_o,
    output logic             irq_o
);
    logic [REG_W-1:0] raw_w;
    logic [REG_W-1:0] mask_w;

    isu_raw_bank #(.REG_W(REG_W), .IMPL_MAP(IMPL_MAP), .LEVEL_MAP(LEVEL_MAP)) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_pulse_i),
        .lvl_i     (lvl_flag_i),
        .clr_we_i  (clr_we_i),
        .clr_data_i(clr_wdata_i),
        .raw_o     (raw_w)
    );

    isu_mask_reg #(.REG_W(REG_W), .IMPL_MAP(IMPL_MAP)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mask_we_i),
        .wdata_i(mask_wdata_i),
        .mask_o (mask_w)
    );

    isu_irq_reduce #(.REG_W(REG_W)) u_red (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (raw_w),
        .mask_i  (mask_w),
        .masked_o(masked_stat_o),
        .irq_o   (irq_o)
    );

    assign raw_stat_o = raw_w;
    assign mask_o     = mask_w;
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
    parameter int unsigned  REG_W     = isu_pkg::ISU_REG_W,
    parameter logic [REG_W-1:0] IMPL_MAP  = isu_pkg::ISU_IMPL_MAP,
    parameter logic [REG_W-1:0] LEVEL_MAP = isu_pkg::ISU_LEVEL_MAP
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] evt_pulse_i,
    input logic [REG_W-1:0] lvl_flag_i,
    input logic             mask_we_i,
    input logic [REG_W-1:0] mask_wdata_i,
    input logic             clr_we_i,
    input logic [REG_W-1:0] clr_wdata_i,
    input logic [REG_W-1:0] raw_stat_o,
    input logic [REG_W-1:0] mask_o,
    input logic [REG_W-1:0] masked_stat_o,
    input logic             irq_o
);
    localparam logic [REG_W-1:0] LVL_B = LEVEL_MAP & IMPL_MAP;
    localparam logic [REG_W-1:0] STK_B = IMPL_MAP & ~LEVEL_MAP;

    logic [REG_W-1:0] clr_eff;
    assign clr_eff = clr_we_i ? clr_wdata_i : '0;

    assert_holes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_stat_o | mask_o | masked_stat_o) & ~IMPL_MAP) == '0);

    assert_level_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_stat_o & LVL_B) == ($past(lvl_flag_i) & LVL_B)));

    assert_sticky_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_stat_o & STK_B) ==
            ((($past(raw_stat_o) & ~$past(clr_eff)) | $past(evt_pulse_i)) & STK_B)));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(evt_pulse_i) & STK_B) & ~raw_stat_o) == '0));

    assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == (|$past(masked_stat_o))));

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mask_we_i) |-> (mask_o == ($past(mask_wdata_i) & IMPL_MAP)));
endmodule

bind irq_status_unit isu_checker #(.REG_W(REG_W), .IMPL_MAP(IMPL_MAP), .LEVEL_MAP(LEVEL_MAP)) u_isu_chk (.*);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
    localparam logic [31:0] IMPL = 32'h131F_007F;
    localparam logic [31:0] LVL  = 32'h0000_0077;
    localparam logic [31:0] STK  = IMPL & ~LVL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0, lvl = '0, mwd = '0, cwd = '0;
    logic        mwe = 1'b0, cwe = 1'b0;
    logic [31:0] raw, msk, mskd;
    logic        irq;
    int          checks = 0, errors = 0;

    always #5 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(evt), .lvl_flag_i(lvl),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .clr_we_i(cwe), .clr_wdata_i(cwd),
        .raw_stat_o(raw), .mask_o(msk), .masked_stat_o(mskd), .irq_o(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 raw", raw, 32'h0);
        chk("R1 mask", msk, 32'h0);
        chk("R1 masked", mskd, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 raw after release", raw, 32'h0);

        for (int b = 0; b < 32; b++) begin
            logic [31:0] e, st, lv;
            string cls;
            e  = 32'h1 << b;
            st = STK & e;
            lv = LVL & e;
            cls = ((IMPL & e) == 0) ? "R5" : "R2";
            // latch and hold
            evt = e; tick(); evt = '0;
            chk(cls, raw, st);
            tick();
            chk(cls, raw, st);
            // mask everything
            mwe = 1'b1; mwd = '1; tick(); mwe = 1'b0;
            chk("R9", msk, IMPL);
            chk("R6", mskd, st);
            tick();
            chk("R7", {31'h0, irq}, {31'h0, (st != 0)});
            // clear with a complementary word: no effect
            cwe = 1'b1; cwd = ~e; tick(); cwe = 1'b0;
            chk("R3 zero bits", raw, st);
            // clear with matching word
            cwe = 1'b1; cwd = e; tick(); cwe = 1'b0;
            chk("R3", raw, 32'h0);
            tick();
            chk("R7 fall", {31'h0, irq}, 32'h0);
            // level following, immune to clear
            lvl = e; tick();
            chk("R4 follow", raw, lv);
            cwe = 1'b1; cwd = e; tick(); cwe = 1'b0;
            chk("R4 clear ignored", raw, lv);
            lvl = '0; tick();
            chk("R4 drop", raw, 32'h0);
            // collision: set beats clear
            evt = e; cwe = 1'b1; cwd = e; tick(); evt = '0; cwe = 1'b0;
            chk("R8", raw, st);
            cwe = 1'b1; cwd = '1; tick(); cwe = 1'b0;
            chk("R3 all", raw, 32'h0);
            mwe = 1'b1; mwd = '0; tick(); mwe = 1'b0;
            chk("R9 zero", msk, 32'h0);
        end

        // whole-word patterns
        evt = '1; lvl = '1; tick(); evt = '0;
        chk("R5 word", raw, IMPL);
        mwe = 1'b1; mwd = 32'hAAAA_AAAA; tick(); mwe = 1'b0;
        chk("R9 pattern", msk, IMPL & 32'hAAAA_AAAA);
        chk("R6 pattern", mskd, IMPL & 32'hAAAA_AAAA);
        mwd = 32'h5555_5555; tick();
        chk("R9 held", msk, IMPL & 32'hAAAA_AAAA);
        lvl = '0; cwe = 1'b1; cwd = '1; tick(); cwe = 1'b0;
        chk("R6 cleared", mskd, 32'h0);
        tick();
        chk("R7 idle", {31'h0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule